// File: doc/BRIEF.md
# FEC Receive Control and Status Registers

This block is the software-visible register bank that sits beside a receive-side Reed-Solomon FEC decoder. A simple word-addressed bus (address, read strobe, write strobe, 32-bit write data, registered 32-bit read data with a read-valid flag) reaches eight registers in a window that begins at a parameterised base address. The window holds:

- four fixed identification words;
- a control register that drives the decoder's correction-bypass level and its alignment-restart request;
- a status word that mirrors the decoder's alignment-marker lock;
- two event counters.

The decoder reports each corrected and each uncorrected codeword with a one-cycle pulse, and the bank counts these pulses. A bus read of a counter returns its value and starts it again from zero. The restart request stays raised until the decoder answers with a one-cycle restart-done pulse. The decoder datapath is outside this block.

Top module: `fec_rx_csr`

## Requirements
- R1: Reads of offsets 0, 1, 2 and 3 from the base address (default base 0xD00) return 0x05042018, 0x32356765, 0x52534645 and 0x436F5258.
- R2: A write to offset 4 stores write-data bit 0, and `bypass_en` shows it from the cycle after the write. A read of offset 4 returns bit 0 and bit 4 with every other bit zero, whatever was written.
- R3: A write to offset 4 stores write-data bit 4 as the restart bit, and `restart_req` equals that bit. A one-cycle `restart_done` pulse clears the bit. When a write and `restart_done` arrive in the same cycle, the write wins.
- R4: A read of offset 5 returns `align_lock` in bit 0, as sampled in the read-strobe cycle, with all other bits zero.
- R5: Offset 6 counts `ev_corrected` pulses and offset 7 counts `ev_uncorrected` pulses, one per cycle in which the pulse is high.
- R6: Each counter is CNT_W bits wide (default 32), zero-extended on reads, and holds at all-ones instead of wrapping.
- R7: A read of a counter returns its current value, and the counter is zero afterwards.
- R8: When an event pulse arrives in the same cycle as a read of its counter, the read returns the value before that pulse, and the counter holds 1 afterwards.
- R9: Writes to offsets 0–3 and 5–7 have no effect on any register.
- R10: Read data and `bus_rvalid` appear one clock after the read strobe. Reads outside the eight-word window return zero, and `bus_rdata` is zero in cycles without read data.
- R11: A synchronous active-low reset clears the control bits, both counters, `bus_rvalid` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Word address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| ev_corrected | input | 1 | One-cycle pulse per corrected codeword |
| ev_uncorrected | input | 1 | One-cycle pulse per uncorrected codeword |
| align_lock | input | 1 | Alignment-marker lock from the decoder |
| restart_done | input | 1 | One-cycle pulse: alignment restart has taken place |
| bypass_en | output | 1 | Correction bypass level to the decoder |
| restart_req | output | 1 | Alignment-restart request to the decoder |

## Verification
A wrong control bit is visible on `bypass_en` or `restart_req` in the cycle after the write or done pulse that should have set it. It also shows in the next read of offset 4. A wrong counter state stays hidden until the next read of that counter, which then returns a wrong value. A missed clear shows on the following read as a non-zero count. The scoreboard therefore reads each counter twice around every boundary: the saturation limit, the clearing read, and a pulse in the same cycle as a read.

// File: rtl/fec_rx_csr_pkg.sv
// Package: shared register offsets and fixed identification values for
// the FEC receive register bank. Assumes a 32-bit data bus.
package fec_rx_csr_pkg;
    localparam int DATA_W = 32;

    localparam logic [2:0] OFS_REV   = 3'd0;
    localparam logic [2:0] OFS_ID0   = 3'd1;
    localparam logic [2:0] OFS_ID1   = 3'd2;
    localparam logic [2:0] OFS_ID2   = 3'd3;
    localparam logic [2:0] OFS_CTRL  = 3'd4;
    localparam logic [2:0] OFS_STAT  = 3'd5;
    localparam logic [2:0] OFS_CORR  = 3'd6;
    localparam logic [2:0] OFS_UNCOR = 3'd7;

    localparam int CTRL_BYP_BIT = 0;
    localparam int CTRL_RST_BIT = 4;

    localparam logic [DATA_W-1:0] VAL_REV = 32'h0504_2018;
    localparam logic [DATA_W-1:0] VAL_ID0 = 32'h3235_6765;
    localparam logic [DATA_W-1:0] VAL_ID1 = 32'h5253_4645;
    localparam logic [DATA_W-1:0] VAL_ID2 = 32'h436F_5258;
endpackage

// File: rtl/fec_rx_csr_cnt.sv
// Saturating event counter that clears when it is read.
// Assumes inc and clr are single-cycle qualified strobes. When clr and inc
// coincide, the counter restarts at 1 so that the event is not lost.
module fec_rx_csr_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Count events: clear on read, hold at the maximum value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= inc ? CNT_ONE : '0;
        end else if (inc && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign value = cnt_q;
endmodule

// File: rtl/fec_rx_csr_ctrl.sv
// Control register: bypass level and alignment-restart request.
// Assumes wr_en is already decoded for the control offset. A write has
// priority over restart_done arriving in the same cycle.
module fec_rx_csr_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_byp,
    input  logic wr_rst,
    input  logic restart_done,
    output logic byp_q,
    output logic rst_q
);
    // Hold the bypass bit, written only by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_q <= 1'b0;
        end else if (wr_en) begin
            byp_q <= wr_byp;
        end
    end

    // Hold the restart bit until the decoder confirms the restart
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= 1'b0;
        end else if (wr_en) begin
            rst_q <= wr_rst;
        end else if (restart_done) begin
            rst_q <= 1'b0;
        end
    end
endmodule

// File: rtl/fec_rx_csr.sv
// Register bank for a receive-side Reed-Solomon FEC decoder.
// Eight words start at BASE_ADDR, which must be a multiple of 8.
// Read data is registered, so it appears one cycle after bus_rd.
// CNT_W must not exceed 32.
module fec_rx_csr
    import fec_rx_csr_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'hD00,
    parameter int              CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              ev_corrected,
    input  logic              ev_uncorrected,
    input  logic              align_lock,
    input  logic              restart_done,
    output logic              bypass_en,
    output logic              restart_req
);
    localparam int NUM_CNT = 2;

    logic              win_hit;
    logic [2:0]        ofs;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [NUM_CNT-1:0] cnt_clr;
    logic [CNT_W-1:0]  cnt_val [NUM_CNT];
    logic              byp_q;
    logic              rst_q;
    logic [DATA_W-1:0] rd_mux;

    // Decode the eight-word window and the offset inside it
    always_comb begin
        win_hit = (bus_addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);
        ofs     = bus_addr[2:0];
    end

    assign cnt_inc = {ev_uncorrected, ev_corrected};

    // One read-clear counter per codeword outcome
    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        assign cnt_clr[gi] = bus_rd && win_hit && (ofs == (OFS_CORR + 3'(gi)));

        fec_rx_csr_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[gi]),
            .clr   (cnt_clr[gi]),
            .value (cnt_val[gi])
        );
    end

    fec_rx_csr_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bus_wr && win_hit && (ofs == OFS_CTRL)),
        .wr_byp       (bus_wdata[CTRL_BYP_BIT]),
        .wr_rst       (bus_wdata[CTRL_RST_BIT]),
        .restart_done (restart_done),
        .byp_q        (byp_q),
        .rst_q        (rst_q)
    );

    assign bypass_en   = byp_q;
    assign restart_req = rst_q;

    // Select the read value for the addressed word
    always_comb begin
        rd_mux = '0;
        if (win_hit) begin
            unique case (ofs)
                OFS_REV:   rd_mux = VAL_REV;
                OFS_ID0:   rd_mux = VAL_ID0;
                OFS_ID1:   rd_mux = VAL_ID1;
                OFS_ID2:   rd_mux = VAL_ID2;
                OFS_CTRL: begin
                    rd_mux[CTRL_BYP_BIT] = byp_q;
                    rd_mux[CTRL_RST_BIT] = rst_q;
                end
                OFS_STAT:  rd_mux[0] = align_lock;
                OFS_CORR:  rd_mux = DATA_W'(cnt_val[0]);
                OFS_UNCOR: rd_mux = DATA_W'(cnt_val[1]);
                default:   rd_mux = '0;
            endcase
        end
    end

    // Register the read data and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rdata  <= bus_rd ? rd_mux : '0;
            bus_rvalid <= bus_rd;
        end
    end
endmodule

// File: rtl/fec_rx_csr_chk.sv
// Checker for the FEC receive register bank, observing its ports only.
// Assumes the same parameters as the bound instance.
module fec_rx_csr_chk
    import fec_rx_csr_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 12'hD00
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic              restart_done,
    input logic              bypass_en,
    input logic              restart_req
);
    logic ctrl_wr;
    logic in_win;

    assign ctrl_wr = bus_wr && (bus_addr == BASE_ADDR + ADDR_W'(OFS_CTRL));
    assign in_win  = (bus_addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);

    // R10
    rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R10
    no_spurious_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (!bus_rvalid && bus_rdata == '0));

    // R10
    outside_window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_win) |=> (bus_rdata == '0));

    // R1
    revision_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == BASE_ADDR) |=> (bus_rdata == VAL_REV));

    // R2
    bypass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(bypass_en));

    // R3
    restart_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_req) |-> $past(ctrl_wr && bus_wdata[CTRL_RST_BIT]));

    // R3
    restart_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(restart_req) |-> $past(restart_done || ctrl_wr));
endmodule

bind fec_rx_csr fec_rx_csr_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .bus_rvalid   (bus_rvalid),
    .restart_done (restart_done),
    .bypass_en    (bypass_en),
    .restart_req  (restart_req)
);

// File: tb/fec_rx_csr_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for fec_rx_csr. Runs with an 8-bit counter so that
// saturation can be reached within a short run.
module fec_rx_csr_tb;
    localparam int ADDR_W = 12;
    localparam int CNT_W  = 8;
    localparam logic [ADDR_W-1:0] BASE = 12'hD00;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_rd = 1'b0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic              ev_corrected = 1'b0;
    logic              ev_uncorrected = 1'b0;
    logic              align_lock = 1'b0;
    logic              restart_done = 1'b0;
    logic              bypass_en;
    logic              restart_req;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    fec_rx_csr #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .ev_corrected(ev_corrected),
        .ev_uncorrected(ev_uncorrected), .align_lock(align_lock),
        .restart_done(restart_done), .bypass_en(bypass_en),
        .restart_req(restart_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Driver: issue a read and push the expected word
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse_corr(input int n);
        for (int i = 0; i < n; i++) begin
            ev_corrected = 1'b1; @(negedge clk); ev_corrected = 1'b0;
        end
    endtask

    task automatic pulse_uncor(input int n);
        for (int i = 0; i < n; i++) begin
            ev_uncorrected = 1'b1; @(negedge clk); ev_uncorrected = 1'b0;
        end
    endtask

    // Monitor: pop and compare on every valid read
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected rvalid", 32'd1, 32'd0);
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        check("R10 pending reads", 32'(exp_q.size()), 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        check("watchdog", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R11: reset state
        check("R11 bypass_en", 32'(bypass_en), 32'd0);
        check("R11 restart_req", 32'(restart_req), 32'd0);
        check("R11 rvalid", 32'(bus_rvalid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: identification words
        rd(BASE + 0, 32'h0504_2018, "R1 rev");
        rd(BASE + 1, 32'h3235_6765, "R1 id0");
        rd(BASE + 2, 32'h5253_4645, "R1 id1");
        rd(BASE + 3, 32'h436F_5258, "R1 id2");
        // R10: outside the window
        rd(BASE + 8, 32'h0, "R10 above");
        rd(12'hC07, 32'h0, "R10 below");

        // R2: bypass plus reserved bits
        wr(BASE + 4, 32'hFFFF_FFEF);
        check("R2 bypass_en set", 32'(bypass_en), 32'd1);
        check("R3 restart low", 32'(restart_req), 32'd0);
        rd(BASE + 4, 32'h0000_0001, "R2 ctrl readback");

        // R3: restart request held until done
        wr(BASE + 4, 32'h0000_0011);
        check("R3 restart set", 32'(restart_req), 32'd1);
        @(negedge clk); @(negedge clk);
        check("R3 restart held", 32'(restart_req), 32'd1);
        rd(BASE + 4, 32'h0000_0011, "R3 ctrl readback");
        restart_done = 1'b1; @(negedge clk); restart_done = 1'b0;
        check("R3 restart cleared", 32'(restart_req), 32'd0);
        check("R2 bypass kept", 32'(bypass_en), 32'd1);
        // R3: write and done in the same cycle: write wins
        restart_done = 1'b1;
        wr(BASE + 4, 32'h0000_0010);
        restart_done = 1'b0;
        check("R3 write beats done", 32'(restart_req), 32'd1);
        check("R2 bypass cleared", 32'(bypass_en), 32'd0);
        restart_done = 1'b1; @(negedge clk); restart_done = 1'b0;
        check("R3 restart cleared again", 32'(restart_req), 32'd0);

        // R4: status
        align_lock = 1'b0;
        rd(BASE + 5, 32'h0, "R4 unlocked");
        align_lock = 1'b1;
        rd(BASE + 5, 32'h1, "R4 locked");

        // R5, R9: count events, writes to read-only words ignored
        pulse_corr(5);
        pulse_uncor(3);
        wr(BASE + 0, 32'h1234_5678);
        wr(BASE + 5, 32'hFFFF_FFFF);
        wr(BASE + 6, 32'h0000_0055);
        wr(BASE + 7, 32'h0000_00AA);
        check("R9 bypass untouched", 32'(bypass_en), 32'd0);
        check("R9 restart untouched", 32'(restart_req), 32'd0);
        rd(BASE + 0, 32'h0504_2018, "R9 rev unchanged");
        rd(BASE + 6, 32'd5, "R5 corrected count");
        rd(BASE + 7, 32'd3, "R5 uncorrected count");
        // R7: cleared by read
        rd(BASE + 6, 32'd0, "R7 corrected cleared");
        rd(BASE + 7, 32'd0, "R7 uncorrected cleared");

        // R6: saturation at all-ones
        pulse_corr(300);
        rd(BASE + 6, 32'd255, "R6 saturated");
        rd(BASE + 6, 32'd0, "R7 cleared after saturation");
        pulse_uncor(255);
        rd(BASE + 7, 32'd255, "R6 exact max");

        // R8: event in the same cycle as the clearing read
        pulse_corr(2);
        ev_corrected = 1'b1;
        rd(BASE + 6, 32'd2, "R8 read returns old value");
        ev_corrected = 1'b0;
        rd(BASE + 6, 32'd1, "R8 counter restarts at one");

        @(negedge clk); @(negedge clk);
        finish_run();
    end
endmodule